// File: doc/BRIEF.md
# Acquisition Trigger Controller

This block decides when a data-acquisition front end receives conversion strobes. One mode word picks the conversion source: the software start strobe, a pacer tick, a burst tick, or a rising edge on the digital interrupt line. A separately chosen start source opens the acquisition window and a separately chosen stop source closes it. The window can also follow the level of the external trigger line. It can run on for a programmed number of further samples after the stop event, or end on a sample count.

The external trigger and the interrupt line are asynchronous. Each passes through a two-flop synchronizer and a filter that accepts a new level only after two equal samples. The software strobe, the user-timer terminal-count pulse, the pacer tick and the burst tick are one-clock synchronous pulses. When a cycle completes, the block either waits for the next start event (repeat) or stays idle until the mode word is written again (single cycle). A write of the mode word aborts any running cycle.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `conv_strobe` are 0. The mode word resets to 0, which means software conversion, software start, software stop and single cycle.
- R2: A conversion strobe appears one clock after the selected tick, and only while the window is open. The tick is selected by mode bits [1:0]: 00 software strobe, 01 pacer tick, 10 burst tick inside an open burst, 11 interrupt rising edge. Ticks from the other sources give no strobe.
- R3: From idle, the start event is selected by mode bits [4:2]: 000 software strobe, 001 external edge, 010 interrupt rising edge, 011 timer terminal count. `busy` rises on the clock that samples the event. Codes 100 to 110 never start a cycle.
- R4: With start code 111, the window is open exactly while the filtered external line is at its active level: high when mode bit 10 is 0, low when it is 1. The stop field is ignored in this mode, and the cycle completes when the line leaves the active level.
- R5: Stop codes in mode bits [7:5] of 000, 001 and 010 (software strobe, external edge, interrupt rising edge) end a running cycle. `busy` falls and `done` pulses for one clock. A tick in the same cycle as the stop event still yields its strobe.
- R6: With stop code 011, the start event loads the 16-bit count register. Each strobe decrements the count, and `done` pulses on the strobe that brings it to zero. A count of zero completes the cycle one clock after the start event, with no strobes.
- R7: Stop codes 100 to 111 take their stop event from the software strobe, the external edge, the interrupt rising edge or the timer terminal count, in that code order. Exactly the count-register number of strobes follows the stop event, and then `done` pulses. A strobe coinciding with the stop event is not counted, and a count of zero ends the cycle one clock after the stop event.
- R8: With mode bit 10 at 0, only rising external edges are trigger events. With mode bit 10 at 1, only falling external edges are.
- R9: An external or interrupt pulse lasting a single clock produces no event.
- R10: With mode bit 11 at 0 (single cycle), the block ignores all start events after a completion until the mode word is written.
- R11: With mode bit 11 at 1 (repeat), the block rearms after each completion. Start events that arrive during a running cycle have no effect.
- R12: In burst conversion mode, a launch event opens a burst of BURST_LEN strobes on successive burst ticks while the window is open. The launch event is selected by mode bits [9:8]: 00 software strobe, 01 pacer tick, 10 external edge, 11 interrupt rising edge. Launches during an unfinished burst are ignored.
- R13: A mode-word write (`cfg_wr` with `cfg_sel` 0) returns the block to idle on that clock, without a `done` pulse or a strobe. A `cfg_sel` 1 write sets the count register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 selects the mode word, 1 selects the count register |
| cfg_wdata | input | 16 | Write data |
| sw_start | input | 1 | Software start strobe, one-clock pulse |
| ext_trig | input | 1 | External trigger line, asynchronous |
| dig_irq | input | 1 | Digital interrupt line, asynchronous |
| utc_tc | input | 1 | User-timer terminal-count pulse |
| pacer_tick | input | 1 | Pacer clock tick pulse |
| burst_tick | input | 1 | Burst clock tick pulse |
| conv_strobe | output | 1 | Conversion strobe, one clock wide |
| busy | output | 1 | Acquisition window active |
| done | output | 1 | One-clock pulse when a cycle completes |

## Verification
Two events can fall in the same cycle here: a conversion tick and the stop event. The bench drives the software strobe and a pacer tick on the same clock. With a plain software stop, it expects one strobe and a `done` pulse in the same output cycle. In post-stop sample mode with a count of two, it expects the coincident strobe to go uncounted, so three strobes appear in total before `done`.

// File: rtl/atc_pkg.sv
// Package: shared types for the acquisition trigger controller.
// Assumes the mode word layout below; all modules decode it through atc_mode_t.
package atc_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_POST = 2'd2,
        ST_HALT = 2'd3
    } atc_state_e;

    typedef struct packed {
        logic       repeat_en;  // bit 11
        logic       pol;        // bit 10
        logic [1:0] burst_src;  // bits 9:8
        logic [2:0] stop_src;   // bits 7:5
        logic [2:0] start_src;  // bits 4:2
        logic [1:0] conv_src;   // bits 1:0
    } atc_mode_t;

    localparam logic [2:0] START_GATED = 3'b111;
    localparam logic [2:0] STOP_COUNT  = 3'b011;
    localparam logic [1:0] CONV_BURST  = 2'b10;

endpackage

// File: rtl/atc_edge_filt.sv
// Module: atc_edge_filt
// Synchronizes one asynchronous line with two flops. It then accepts a new
// level only when two consecutive synchronized samples agree, so a pulse of
// one clock is discarded. `flip` is high in the cycle before lvl_q inverts.
// Assumes the line is low when reset is released.
module atc_edge_filt (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl_q,
    output logic flip
);
    logic [2:0] sh_q;

    // Purpose: synchronizer chain plus one delay stage, and the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            lvl_q <= 1'b0;
        end else begin
            sh_q <= {sh_q[1:0], din};
            if (sh_q[1] == sh_q[2]) lvl_q <= sh_q[1];
        end
    end

    // Purpose: announce an accepted level change one cycle ahead of lvl_q.
    always_comb flip = (sh_q[1] == sh_q[2]) && (sh_q[1] != lvl_q);

    p_level_agrees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(sh_q[1] == sh_q[2]));

    p_flip_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> !$stable(lvl_q));

endmodule

// File: rtl/atc_burst.sv
// Module: atc_burst
// Burst window counter. While enabled, a launch with no burst pending loads
// BURST_LEN. Each burst tick then spends one slot until none remain. Dropping
// the enable clears any remaining slots. Assumes tick and launch are one-clock
// pulses.
module atc_burst #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic launch,
    input  logic tick,
    output logic gate
);
    localparam int RW = $clog2(BURST_LEN + 1);
    localparam logic [RW-1:0] LEN = RW'(BURST_LEN);

    logic [RW-1:0] rem_q;

    // Purpose: track remaining strobes of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rem_q <= '0;
        else if (!en)                      rem_q <= '0;
        else if (tick && rem_q != '0)      rem_q <= rem_q - 1'b1;
        else if (launch && rem_q == '0)    rem_q <= LEN;
    end

    // Purpose: a burst tick may convert only while slots remain.
    always_comb gate = (rem_q != '0);

    p_burst_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= LEN);

    p_burst_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && launch && rem_q == '0) |=> rem_q == LEN);

    p_burst_nolaunch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && launch && !tick && rem_q != '0) |=> $stable(rem_q));

endmodule

// File: rtl/atc_seq.sv
// Module: atc_seq
// Acquisition window state machine with the post-stop sample counter.
// States: idle, run (window open), post (counting samples), halt (single
// cycle spent). Assumes start_ev, stop_ev and conv_tick are already decoded
// from the current mode word. Strobe and done are registered.
module atc_seq
    import atc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  atc_mode_t        mode,
    input  logic             mode_wr,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             gate_act,
    input  logic             conv_tick,
    output logic             win_open,
    output logic             conv_strobe,
    output logic             busy,
    output logic             done
);
    atc_state_e       state_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             fire, fin, gated, about, cnt_stop;

    // Purpose: decode mode flags and the open-window condition.
    always_comb begin
        gated    = (mode.start_src == START_GATED);
        about    = mode.stop_src[2];
        cnt_stop = (mode.stop_src == STOP_COUNT);
        win_open = (state_q == ST_RUN) || (state_q == ST_POST && cnt_q != '0);
        fire     = win_open && conv_tick;
    end

    // Purpose: next-state and counter logic of the acquisition window.
    always_comb begin
        st_n  = state_q;
        cnt_n = cnt_q;
        fin   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (gated) begin
                    if (gate_act) st_n = ST_RUN;
                end else if (start_ev) begin
                    if (cnt_stop) begin
                        st_n  = ST_POST;
                        cnt_n = cnt_init;
                    end else begin
                        st_n = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (gated) begin
                    if (!gate_act) fin = 1'b1;
                end else if (stop_ev) begin
                    if (about) begin
                        st_n  = ST_POST;
                        cnt_n = cnt_init;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            ST_POST: begin
                if (cnt_q == '0) begin
                    fin = 1'b1;
                end else if (fire) begin
                    cnt_n = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) fin = 1'b1;
                end
            end
            default: ;
        endcase
        if (fin) st_n = mode.repeat_en ? ST_IDLE : ST_HALT;
        if (mode_wr) begin
            st_n = ST_IDLE;
            fin  = 1'b0;
        end
    end

    // Purpose: state, counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            conv_strobe <= 1'b0;
            done        <= 1'b0;
        end else begin
            state_q     <= st_n;
            cnt_q       <= cnt_n;
            conv_strobe <= fire && !mode_wr;
            done        <= fin;
        end
    end

    // Purpose: window status for the outside.
    always_comb busy = (state_q == ST_RUN) || (state_q == ST_POST);

    p_strobe_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> $past(win_open));

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_gate_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && state_q == ST_IDLE && gate_act && !mode_wr) |=> busy);

    p_post_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && conv_tick && cnt_q > CNT_W'(1) && !mode_wr)
            |=> (state_q == ST_POST && cnt_q == $past(cnt_q) - 1'b1));

    p_halt_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !mode_wr) |=> state_q == ST_HALT);

    p_run_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !gated && !stop_ev && !mode_wr) |=> state_q == ST_RUN);

    p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (!busy && !done && !conv_strobe));

endmodule

// File: rtl/acq_trig_ctrl.sv
// Module: acq_trig_ctrl (top)
// Holds the mode word and the count register. Filters the asynchronous
// trigger and interrupt lines, decodes the start, stop, burst-launch and
// conversion sources, and drives the window sequencer.
// Assumes sw_start, utc_tc, pacer_tick and burst_tick are synchronous
// one-clock pulses, and CNT_W <= DATA_W.
module acq_trig_ctrl
    import atc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              sw_start,
    input  logic              ext_trig,
    input  logic              dig_irq,
    input  logic              utc_tc,
    input  logic              pacer_tick,
    input  logic              burst_tick,
    output logic              conv_strobe,
    output logic              busy,
    output logic              done
);
    localparam int NLINE = 2;   // index 0: external trigger, 1: interrupt

    atc_mode_t        mode_q;
    logic [CNT_W-1:0] cnt_init_q;
    logic             mode_wr;
    logic [NLINE-1:0] line_raw, line_lvl, line_flip;
    logic             ext_ev, irq_ev, gate_act;
    logic             start_ev, stop_ev, launch_ev, conv_tick;
    logic             win_open, burst_gate, burst_en;

    // Purpose: register write port for the mode word and count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            cnt_init_q <= '0;
        end else if (cfg_wr) begin
            if (!cfg_sel) mode_q     <= atc_mode_t'(cfg_wdata[MODE_W-1:0]);
            else          cnt_init_q <= cfg_wdata[CNT_W-1:0];
        end
    end

    // Purpose: a mode-word write aborts the running cycle.
    always_comb mode_wr = cfg_wr && !cfg_sel;

    // Purpose: route the asynchronous lines into the filters.
    always_comb line_raw = {dig_irq, ext_trig};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        atc_edge_filt u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (line_raw[g]),
            .lvl_q (line_lvl[g]),
            .flip  (line_flip[g])
        );
    end

    // Purpose: polarity-qualified external edge, interrupt rising edge, gate level.
    always_comb begin
        ext_ev   = line_flip[0] && (line_lvl[0] == mode_q.pol);
        irq_ev   = line_flip[1] && !line_lvl[1];
        gate_act = line_lvl[0] ^ mode_q.pol;
    end

    // Purpose: decode start, stop, burst-launch and conversion sources.
    always_comb begin
        case (mode_q.start_src)
            3'b000:  start_ev = sw_start;
            3'b001:  start_ev = ext_ev;
            3'b010:  start_ev = irq_ev;
            3'b011:  start_ev = utc_tc;
            default: start_ev = 1'b0;
        endcase
        case (mode_q.stop_src[1:0])
            2'b00:   stop_ev = sw_start;
            2'b01:   stop_ev = ext_ev;
            2'b10:   stop_ev = irq_ev;
            default: stop_ev = utc_tc && mode_q.stop_src[2];
        endcase
        case (mode_q.burst_src)
            2'b00:   launch_ev = sw_start;
            2'b01:   launch_ev = pacer_tick;
            2'b10:   launch_ev = ext_ev;
            default: launch_ev = irq_ev;
        endcase
        case (mode_q.conv_src)
            2'b00:   conv_tick = sw_start;
            2'b01:   conv_tick = pacer_tick;
            2'b10:   conv_tick = burst_tick && burst_gate;
            default: conv_tick = irq_ev;
        endcase
        burst_en = win_open && (mode_q.conv_src == CONV_BURST);
    end

    atc_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (burst_en),
        .launch (launch_ev),
        .tick   (burst_tick),
        .gate   (burst_gate)
    );

    atc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .mode_wr     (mode_wr),
        .cnt_init    (cnt_init_q),
        .start_ev    (start_ev),
        .stop_ev     (stop_ev),
        .gate_act    (gate_act),
        .conv_tick   (conv_tick),
        .win_open    (win_open),
        .conv_strobe (conv_strobe),
        .busy        (busy),
        .done        (done)
    );

    p_ext_edge_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ev |=> (line_lvl[0] != mode_q.pol || $past(mode_wr)));

    p_strobe_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> $past(sw_start || pacer_tick || burst_tick || line_flip[1]));

endmodule

// File: tb/sim_acq_trig_ctrl.sv
module sim_acq_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        sw_start = 1'b0, ext_trig = 1'b0, dig_irq = 1'b0;
    logic        utc_tc = 1'b0, pacer_tick = 1'b0, burst_tick = 1'b0;
    logic        conv_strobe, busy, done;

    int n_chk = 0, n_err = 0, n_str = 0, n_done = 0, n_both = 0;

    always #10 clk = ~clk;

    acq_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sw_start(sw_start), .ext_trig(ext_trig),
        .dig_irq(dig_irq), .utc_tc(utc_tc), .pacer_tick(pacer_tick),
        .burst_tick(burst_tick), .conv_strobe(conv_strobe), .busy(busy),
        .done(done)
    );

    // Row: mode, count, start kind (0 sw,1 timer,2 none), pre ticks,
    // stop kind (0 sw,1 timer,2 none), post ticks, exp strobes, exp done, exp busy
    localparam logic [37:0] TBL [8] = '{
        {12'h801, 8'd0, 2'd0, 4'd5, 2'd0, 4'd0, 4'd5, 1'b1, 1'b0},
        {12'h86D, 8'd3, 2'd1, 4'd6, 2'd2, 4'd0, 4'd3, 1'b1, 1'b0},
        {12'h881, 8'd2, 2'd0, 4'd3, 2'd0, 4'd5, 4'd5, 1'b1, 1'b0},
        {12'h881, 8'd0, 2'd0, 4'd3, 2'd0, 4'd4, 4'd3, 1'b1, 1'b0},
        {12'h86C, 8'd4, 2'd1, 4'd6, 2'd2, 4'd0, 4'd4, 1'b1, 1'b0},
        {12'h811, 8'd0, 2'd0, 4'd4, 2'd2, 4'd0, 4'd0, 1'b0, 1'b0},
        {12'h8E1, 8'd1, 2'd0, 4'd2, 2'd1, 4'd3, 4'd3, 1'b1, 1'b0},
        {12'h801, 8'd0, 2'd0, 4'd3, 2'd2, 4'd0, 4'd3, 1'b0, 1'b1}
    };

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_strobe) n_str++;
            if (done) n_done++;
            if (conv_strobe && done) n_both++;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: sw_start = 1'b1;
            1: utc_tc = 1'b1;
            2: pacer_tick = 1'b1;
            default: burst_tick = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; utc_tc = 1'b0; pacer_tick = 1'b0; burst_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        @(posedge clk);
        n_str = 0; n_done = 0; n_both = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual expired expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 strobe after reset", int'(conv_strobe), 0);

        // Table walk: R2 R3 R5 R6 R7 under synchronous sources
        for (int i = 0; i < 8; i++) begin
            logic [37:0] r;
            r = TBL[i];
            wr(1'b1, {8'd0, r[25:18]});
            wr(1'b0, {4'd0, r[37:26]});
            clr();
            if (r[17:16] != 2'd2) pulse(r[17:16] == 2'd1 ? 1 : 0);
            for (int j = 0; j < int'(r[15:12]); j++) pulse(r[27:26] == 2'd0 ? 0 : 2);
            if (r[11:10] != 2'd2) pulse(r[11:10] == 2'd1 ? 1 : 0);
            for (int j = 0; j < int'(r[9:6]); j++) pulse(2);
            idle(4);
            chk($sformatf("R2 R3 R6 R7 row %0d strobes", i), n_str, int'(r[5:2]));
            chk($sformatf("R5 R6 R7 row %0d done", i), n_done, int'(r[1]));
            chk($sformatf("R3 R5 row %0d busy", i), int'(busy), int'(r[0]));
        end

        // R13 abort by mode write
        wr(1'b0, 16'h0801);
        clr();
        pulse(0); pulse(2); idle(2);
        chk("R13 busy before abort", int'(busy), 1);
        wr(1'b0, 16'h0801);
        chk("R13 busy after abort", int'(busy), 0);
        idle(3);
        chk("R13 no done on abort", n_done, 0);
        chk("R13 one strobe only", n_str, 1);

        // R2 interrupt as conversion source, pacer ticks ignored
        wr(1'b0, 16'h0803);
        clr();
        pulse(0); pulse(2); pulse(2); pulse(2);
        @(negedge clk) dig_irq = 1'b1;
        idle(6);
        dig_irq = 1'b0;
        idle(6);
        pulse(0); idle(3);
        chk("R2 interrupt conversions", n_str, 1);
        chk("R5 software stop done", n_done, 1);

        // R8 R9 external edges, rising polarity
        wr(1'b0, 16'h0825);
        clr();
        @(negedge clk) ext_trig = 1'b1;
        @(negedge clk) ext_trig = 1'b0;
        idle(6);
        chk("R9 one-clock glitch ignored", int'(busy), 0);
        ext_trig = 1'b1; idle(6);
        chk("R3 R8 rising edge starts", int'(busy), 1);
        ext_trig = 1'b0; idle(6);
        chk("R8 falling edge ignored", int'(busy), 1);
        pulse(2); pulse(2);
        ext_trig = 1'b1; idle(6);
        chk("R5 rising edge stops", int'(busy), 0);
        chk("R5 external stop strobes", n_str, 2);
        chk("R5 external stop done", n_done, 1);

        // R8 falling polarity
        wr(1'b0, 16'h0C25);
        clr();
        ext_trig = 1'b0; idle(6);
        chk("R8 falling edge starts", int'(busy), 1);
        ext_trig = 1'b1; idle(6);
        chk("R8 rising edge ignored", int'(busy), 1);
        ext_trig = 1'b0; idle(6);
        chk("R8 falling edge stops", n_done, 1);

        // R4 gated mode, active high
        wr(1'b0, 16'h081D);
        clr();
        pulse(2); idle(2);
        chk("R4 closed gate no strobe", n_str, 0);
        ext_trig = 1'b1; idle(6);
        chk("R4 gate opens", int'(busy), 1);
        pulse(2); pulse(2); pulse(2);
        pulse(0); idle(2);
        chk("R4 stop field ignored", int'(busy), 1);
        ext_trig = 1'b0; idle(6);
        chk("R4 gate closes", int'(busy), 0);
        chk("R4 gated strobes", n_str, 3);
        chk("R4 gated done", n_done, 1);

        // R10 single cycle
        wr(1'b0, 16'h0001);
        clr();
        pulse(0); pulse(2); pulse(2); pulse(0); idle(2);
        chk("R10 first cycle done", n_done, 1);
        pulse(0); idle(2);
        chk("R10 start ignored after done", int'(busy), 0);
        pulse(2); idle(2);
        chk("R10 no strobe after done", n_str, 2);
        wr(1'b0, 16'h0001);
        pulse(0); idle(2);
        chk("R10 rearm by mode write", int'(busy), 1);

        // R11 repeat, start during cycle ignored, interrupt stop
        wr(1'b0, 16'h0841);
        clr();
        pulse(0); pulse(2); pulse(0); pulse(2); idle(2);
        chk("R11 start during cycle ignored", int'(busy), 1);
        chk("R11 strobes in cycle", n_str, 2);
        @(negedge clk) dig_irq = 1'b1;
        idle(6);
        chk("R11 cycle completes", n_done, 1);
        dig_irq = 1'b0; idle(6);
        pulse(0); idle(2);
        chk("R11 rearmed", int'(busy), 1);

        // R12 bursts launched by pacer tick
        wr(1'b0, 16'h0902);
        clr();
        pulse(0); pulse(3); pulse(3);
        idle(2);
        chk("R12 no burst before launch", n_str, 0);
        pulse(2);
        for (int k = 0; k < 6; k++) pulse(3);
        idle(2);
        chk("R12 burst length", n_str, 4);
        pulse(2); pulse(3); pulse(3); pulse(2); pulse(3); pulse(3); pulse(3);
        pulse(0); idle(3);
        chk("R12 launch during burst ignored", n_str, 8);
        chk("R12 burst cycle done", n_done, 1);

        // Coincident tick and stop: plain stop
        wr(1'b0, 16'h0801);
        clr();
        pulse(0);
        @(negedge clk); sw_start = 1'b1; pacer_tick = 1'b1;
        @(negedge clk); sw_start = 1'b0; pacer_tick = 1'b0;
        idle(3);
        chk("R5 coincident strobe issued", n_str, 1);
        chk("R5 strobe and done together", n_both, 1);

        // Coincident tick and stop: post-stop count not charged
        wr(1'b1, 16'd2);
        wr(1'b0, 16'h0881);
        clr();
        pulse(0);
        @(negedge clk); sw_start = 1'b1; pacer_tick = 1'b1;
        @(negedge clk); sw_start = 1'b0; pacer_tick = 1'b0;
        pulse(2); pulse(2); pulse(2); idle(3);
        chk("R7 coincident strobe uncounted", n_str, 3);
        chk("R7 coincident done", n_done, 1);

        // R6 zero count ends at once
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h086D);
        clr();
        pulse(1); pulse(2); pulse(2); idle(3);
        chk("R6 zero count strobes", n_str, 0);
        chk("R6 zero count done", n_done, 1);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule